// File: doc/BRIEF.md
# Butterfly Request Network

This block carries memory requests from 2^n requester ports to 2^n memory ports. It is built from n columns of two-input, two-output switching elements. The column for stage k joins the two lines whose indices differ only in bit k, which gives the cube-connected pattern. A request enters with a destination port index, an address, an opcode and a data word. At each stage it is steered by one bit of its destination index. After the last stage it leaves on the port that its index names. Every link between stages uses a valid/ready handshake, so a stalled memory port pushes back toward the requesters and nothing is lost.

Each element has one output register per output, a separate round-robin arbiter for each output, and no other storage. An uncontended request takes exactly n clock cycles, one register per stage. Every requester can reach every memory port, and the network needs only (2^n/2)·n small elements instead of a full crossbar.

Top module: `bfly_net`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, every output valid is low.
- R2: Every accepted request leaves exactly once, on the output port equal to its destination field, with its address, opcode and data unchanged. The request fields are packed as {dest, addr, op, data}.
- R3: An uncontended request accepted on a rising edge shows output valid after the n-th rising edge, counting the accepting edge. On the edge before that, output valid is still low.
- R4: While an output valid is high and its ready is low, that output stays valid and its fields do not change on the next cycle.
- R5: When both inputs of an element want the same output, only one of them is accepted in that cycle. The other sees ready low and must hold its request.
- R6: A stalled memory port fills at most one register per stage on its path. Once the n registers are full, the requester's ready stays low and no request is overwritten.
- R7: Requests from one source to one destination leave in the order they were accepted.
- R8: When the traffic pattern maps each source s to s XOR c for a constant c, and every output is ready, every source is accepted on every cycle.
- R9: Under continuous contention for one output, the two inputs of an element are granted in strict alternation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | NPORT | Request valid, one per requester |
| inReady | output | NPORT | Request accepted this cycle, one per requester |
| inDest | input | NPORT*LOG_PORTS | Destination port index per requester |
| inAddr | input | NPORT*ADDR_W | Address per requester |
| inOp | input | NPORT*OP_W | Opcode per requester |
| inData | input | NPORT*DATA_W | Data per requester |
| outValid | output | NPORT | Request present at memory port |
| outReady | input | NPORT | Memory port takes the request |
| outDest | output | NPORT*LOG_PORTS | Destination field of the delivered request |
| outAddr | output | NPORT*ADDR_W | Delivered address |
| outOp | output | NPORT*OP_W | Delivered opcode |
| outData | output | NPORT*DATA_W | Delivered data |

## Verification
The bench concentrates on contention and backpressure. Two sources aim at one port. An arbiter that never rotates would let one source starve the other, and a grant to both would drop or duplicate a request, which the scoreboard would count as missing or extra items. A memory port is held not-ready while one source keeps sending. A stage that overwrote a full register would lose requests or let more than n through. A wiring error in the stage pairing would show up in the XOR permutation sweeps as stalls, or as requests leaving on the wrong port. Random ready toggling then checks per-pair order and exactly-once delivery.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // strobes from an element's arbiter to its payload registers
  typedef struct packed {
    logic [1:0] load;  // capture a new request into output register o
    logic [1:0] sel;   // which input feeds output register o
  } xbarStrobe_t;

  // lower line index of element `elem` in stage `stage`: insert a zero at bit `stage`
  function automatic int pairLow(input int stage, input int elem);
    return ((elem >> stage) << (stage + 1)) | (elem & ((1 << stage) - 1));
  endfunction

endpackage

// File: rtl/bfly_ctrl.sv
module bfly_ctrl
  import bfly_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  inValid,
  input  logic [1:0]  want,
  output logic [1:0]  inReady,
  output logic [1:0]  outValid,
  input  logic [1:0]  outReady,
  output xbarStrobe_t strobe
);

  logic [1:0]      prio;
  logic [1:0]      free;
  logic [1:0]      contend;
  logic [1:0]      winner;
  logic [1:0]      busy;
  logic [1:0]      granted;
  logic [1:0]      grant;
  logic [1:0][1:0] req;   // req[o][i]

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      for (int i = 0; i < 2; i++) begin
        req[o][i] = inValid[i] && (want[i] == 1'(o));
      end
      free[o]    = !outValid[o] || outReady[o];
      contend[o] = req[o][0] && req[o][1];
      winner[o]  = contend[o] ? prio[o] : req[o][1];
      busy[o]    = req[o][0] || req[o][1];
      granted[o] = busy[o] && free[o];
    end
    for (int i = 0; i < 2; i++) begin
      grant[i] = inValid[i] && granted[want[i]] && (winner[want[i]] == 1'(i));
    end
  end

  assign inReady     = grant;
  assign strobe.load = granted;
  assign strobe.sel  = winner;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= '0;
      prio     <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        if (free[o]) outValid[o] <= granted[o];
        if (contend[o] && granted[o]) prio[o] <= ~winner[o];
      end
    end
  end

  // R5: two inputs never both accepted toward the same output
  p_one_grant_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady[0] && inReady[1] && (want[0] == want[1])));

  generate
    for (genvar o = 0; o < 2; o++) begin : g_chk
      // R6: a full, stalled register is never reloaded
      p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[o] && !outReady[o]) |-> !strobe.load[o]);
      // R9: back-to-back contended grants alternate
      p_rr_fair_r9: assert property (@(posedge clk) disable iff (!rstN)
        (contend[o] && granted[o]) ##1 (contend[o] && granted[o])
          |-> (winner[o] != $past(winner[o])));
    end
  endgenerate

endmodule

// File: rtl/bfly_dp.sv
module bfly_dp
  import bfly_pkg::*;
#(
  parameter int PAY_W = 37
) (
  input  logic                  clk,
  input  xbarStrobe_t           strobe,
  input  logic [1:0][PAY_W-1:0] inPay,
  output logic [1:0][PAY_W-1:0] outPay
);

  always_ff @(posedge clk) begin
    for (int o = 0; o < 2; o++) begin
      if (strobe.load[o]) outPay[o] <= inPay[strobe.sel[o]];
    end
  end

endmodule

// File: rtl/bfly_net.sv
module bfly_net
  import bfly_pkg::*;
#(
  parameter int  LOG_PORTS = 3,
  parameter int  ADDR_W    = 16,
  parameter int  OP_W      = 2,
  parameter int  DATA_W    = 16,
  localparam int NPORT     = 1 << LOG_PORTS
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NPORT-1:0]            inValid,
  output logic [NPORT-1:0]            inReady,
  input  logic [NPORT*LOG_PORTS-1:0]  inDest,
  input  logic [NPORT*ADDR_W-1:0]     inAddr,
  input  logic [NPORT*OP_W-1:0]       inOp,
  input  logic [NPORT*DATA_W-1:0]     inData,
  output logic [NPORT-1:0]            outValid,
  input  logic [NPORT-1:0]            outReady,
  output logic [NPORT*LOG_PORTS-1:0]  outDest,
  output logic [NPORT*ADDR_W-1:0]     outAddr,
  output logic [NPORT*OP_W-1:0]       outOp,
  output logic [NPORT*DATA_W-1:0]     outData
);

  localparam int NSTAGE   = LOG_PORTS;
  localparam int NELEM    = NPORT / 2;
  localparam int DEST_LSB = ADDR_W + OP_W + DATA_W;
  localparam int PAY_W    = DEST_LSB + LOG_PORTS;

  logic             linkValid [NSTAGE+1][NPORT];
  logic             linkReady [NSTAGE+1][NPORT];
  logic [PAY_W-1:0] linkPay   [NSTAGE+1][NPORT];

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign linkValid[0][p] = inValid[p];
      assign linkPay[0][p]   = {inDest[p*LOG_PORTS +: LOG_PORTS],
                                inAddr[p*ADDR_W +: ADDR_W],
                                inOp[p*OP_W +: OP_W],
                                inData[p*DATA_W +: DATA_W]};
      assign inReady[p]      = linkReady[0][p];

      assign outValid[p]             = linkValid[NSTAGE][p];
      assign linkReady[NSTAGE][p]    = outReady[p];
      assign {outDest[p*LOG_PORTS +: LOG_PORTS],
              outAddr[p*ADDR_W +: ADDR_W],
              outOp[p*OP_W +: OP_W],
              outData[p*DATA_W +: DATA_W]} = linkPay[NSTAGE][p];

      // R2: a request only appears on the port its destination names
      p_route_r2: assert property (@(posedge clk) disable iff (!rstN)
        outValid[p] |-> (outDest[p*LOG_PORTS +: LOG_PORTS] == LOG_PORTS'(p)));
      // R4: a stalled output holds
      p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
        (outValid[p] && !outReady[p]) |=> (outValid[p] && $stable(linkPay[NSTAGE][p])));
    end

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
      for (genvar e = 0; e < NELEM; e++) begin : g_elem
        localparam int LO   = pairLow(s, e);
        localparam int HI   = LO + (1 << s);
        localparam int RBIT = DEST_LSB + s;

        logic [1:0]            eInValid;
        logic [1:0]            eWant;
        logic [1:0]            eInReady;
        logic [1:0]            eOutValid;
        logic [1:0]            eOutReady;
        logic [1:0][PAY_W-1:0] eInPay;
        logic [1:0][PAY_W-1:0] eOutPay;
        xbarStrobe_t           eStrobe;

        assign eInValid  = {linkValid[s][HI], linkValid[s][LO]};
        assign eInPay[0] = linkPay[s][LO];
        assign eInPay[1] = linkPay[s][HI];
        assign eWant     = {eInPay[1][RBIT], eInPay[0][RBIT]};
        assign eOutReady = {linkReady[s+1][HI], linkReady[s+1][LO]};

        assign linkReady[s][LO]   = eInReady[0];
        assign linkReady[s][HI]   = eInReady[1];
        assign linkValid[s+1][LO] = eOutValid[0];
        assign linkValid[s+1][HI] = eOutValid[1];
        assign linkPay[s+1][LO]   = eOutPay[0];
        assign linkPay[s+1][HI]   = eOutPay[1];

        bfly_ctrl u_ctrl (
          .clk      (clk),
          .rstN     (rstN),
          .inValid  (eInValid),
          .want     (eWant),
          .inReady  (eInReady),
          .outValid (eOutValid),
          .outReady (eOutReady),
          .strobe   (eStrobe)
        );

        bfly_dp #(.PAY_W(PAY_W)) u_dp (
          .clk    (clk),
          .strobe (eStrobe),
          .inPay  (eInPay),
          .outPay (eOutPay)
        );
      end
    end
  endgenerate

endmodule

// File: tb/bfly_net_test.sv
`timescale 1ns/1ps
module bfly_net_test;

  localparam int LOG = 3;
  localparam int N   = 1 << LOG;
  localparam int AW  = 16;
  localparam int OW  = 2;
  localparam int DW  = 16;
  localparam int PW  = LOG + AW + OW + DW;

  logic              clk = 1'b0;
  logic              rstN;
  logic [N-1:0]      inValid, inReady, outValid, outReady;
  logic [N*LOG-1:0]  inDest, outDest;
  logic [N*AW-1:0]   inAddr, outAddr;
  logic [N*OW-1:0]   inOp, outOp;
  logic [N*DW-1:0]   inData, outData;

  logic              drvValid [N];
  logic [PW-1:0]     drvPay   [N];

  int checks = 0;
  int failures = 0;
  int stallCnt = 0;
  int doneCnt = 0;
  logic [7:0] seqCnt [N];
  logic [PW-1:0] expQ [N*N][$];
  int srcLog [$];
  bit logOn = 0;
  bit randReady = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  always_comb begin
    for (int p = 0; p < N; p++) begin
      inValid[p] = drvValid[p];
      {inDest[p*LOG +: LOG], inAddr[p*AW +: AW], inOp[p*OW +: OW], inData[p*DW +: DW]} = drvPay[p];
    end
  end

  bfly_net #(.LOG_PORTS(LOG), .ADDR_W(AW), .OP_W(OW), .DATA_W(DW)) uut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inDest(inDest), .inAddr(inAddr),
    .inOp(inOp), .inData(inData),
    .outValid(outValid), .outReady(outReady), .outDest(outDest), .outAddr(outAddr),
    .outOp(outOp), .outData(outData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int pending();
    int t = 0;
    for (int i = 0; i < N*N; i++) t += expQ[i].size();
    return t;
  endfunction

  // driver: presents one request from src, holds it until accepted
  task automatic sendReq(input int src, input int dst, input logic [AW-1:0] addr, input logic [OW-1:0] op);
    logic [PW-1:0] pay;
    pay = {LOG'(dst), addr, op, 8'(src), seqCnt[src]};
    seqCnt[src]++;
    @(negedge clk);
    drvPay[src]   = pay;
    drvValid[src] = 1'b1;
    while (1) begin
      #2;
      if (inReady[src]) break;
      stallCnt++;
      @(negedge clk);
    end
    expQ[src*N + dst].push_back(pay);
    @(posedge clk);
    #1;
    drvValid[src] = 1'b0;
  endtask

  // monitor / scoreboard
  initial begin : mon
    logic          prevStall [N];
    logic [PW-1:0] prevPay   [N];
    logic [PW-1:0] pay, e;
    int src, idx;
    for (int p = 0; p < N; p++) prevStall[p] = 1'b0;
    forever begin
      @(negedge clk);
      #2;
      for (int p = 0; p < N; p++) begin
        pay = {outDest[p*LOG +: LOG], outAddr[p*AW +: AW], outOp[p*OW +: OW], outData[p*DW +: DW]};
        if (rstN && prevStall[p])
          check(outValid[p] && (pay == prevPay[p]), "R4 stalled output held", 64'(pay), 64'(prevPay[p]));
        prevStall[p] = rstN && outValid[p] && !outReady[p];
        prevPay[p]   = pay;
        if (rstN && outValid[p] && outReady[p]) begin
          src = int'(pay[15:8]);
          if (src >= N) begin
            check(1'b0, "R2 unknown source", 64'(src), 64'(N));
          end else begin
            idx = src*N + p;
            if (expQ[idx].size() == 0) begin
              check(1'b0, "R2 unexpected or duplicate delivery", 64'(pay), 64'(0));
            end else begin
              e = expQ[idx].pop_front();
              check(pay == e, "R2/R7 payload and order at port", 64'(pay), 64'(e));
            end
            if (logOn && p == 0) srcLog.push_back(src);
          end
        end
      end
    end
  end

  // random ready toggling for the mixed-traffic phase
  initial begin
    forever begin
      @(negedge clk);
      if (randReady) outReady = N'($urandom);
    end
  end

  task automatic drain();
    int w = 0;
    while (pending() != 0 && w < 300) begin
      @(negedge clk);
      w++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 5.0);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    outReady = '1;
    for (int p = 0; p < N; p++) begin
      drvValid[p] = 1'b0;
      drvPay[p]   = '0;
      seqCnt[p]   = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(outValid == '0, "R1 outputs idle in reset", 64'(outValid), 64'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == '0, "R1 outputs idle after reset", 64'(outValid), 64'(0));

    // R3: latency of an uncontended request (source 5 to port 2)
    sendReq(5, 2, 16'h1234, 2'd1);
    repeat (LOG - 2) @(posedge clk);
    @(negedge clk);
    #2;
    check(outValid[2] == 1'b0, "R3 not early", 64'(outValid[2]), 64'(0));
    @(negedge clk);
    #2;
    check(outValid[2] == 1'b1, "R3 arrives after n edges", 64'(outValid[2]), 64'(1));
    drain();

    // R8: conflict-free XOR permutations at full rate
    for (int c = 0; c < N; c++) begin
      stallCnt = 0;
      doneCnt  = 0;
      for (int s = 0; s < N; s++) begin
        fork
          automatic int ss = s;
          automatic int cc = c;
          begin
            repeat (3) sendReq(ss, ss ^ cc, 16'(ss * 16 + cc), 2'(ss));
            doneCnt++;
          end
        join_none
      end
      wait (doneCnt == N);
      check(stallCnt == 0, "R8 no stall in XOR permutation", 64'(stallCnt), 64'(0));
      drain();
    end
    check(pending() == 0, "R2 permutation traffic delivered", 64'(pending()), 64'(0));

    // R5/R9: sources 0 and 1 contend for port 0
    srcLog.delete();
    logOn   = 1'b1;
    doneCnt = 0;
    fork
      begin repeat (6) sendReq(0, 0, 16'hA000, 2'd2); doneCnt++; end
      begin repeat (6) sendReq(1, 0, 16'hB000, 2'd3); doneCnt++; end
    join_none
    wait (doneCnt == 2);
    drain();
    logOn = 1'b0;
    check(srcLog.size() == 12, "R5 all contended requests delivered once", 64'(srcLog.size()), 64'(12));
    for (int i = 1; i < srcLog.size(); i++)
      check(srcLog[i] != srcLog[i-1], "R9 grants alternate", 64'(srcLog[i]), 64'(srcLog[i-1] ^ 1));

    // R4/R6: port 3 stalled while source 4 keeps sending
    outReady[3] = 1'b0;
    doneCnt = 0;
    fork
      begin repeat (5) sendReq(4, 3, 16'hC000, 2'd0); doneCnt++; end
    join_none
    repeat (10) @(negedge clk);
    #2;
    check(expQ[4*N + 3].size() == LOG, "R6 one request per stage", 64'(expQ[4*N + 3].size()), 64'(LOG));
    check(inReady[4] == 1'b0, "R6 requester held off", 64'(inReady[4]), 64'(0));
    check(outValid[3] == 1'b1, "R4 stalled output still valid", 64'(outValid[3]), 64'(1));
    @(negedge clk);
    outReady[3] = 1'b1;
    wait (doneCnt == 1);
    drain();
    check(pending() == 0, "R6 stalled traffic released intact", 64'(pending()), 64'(0));

    // R2/R7: random traffic with random output ready
    randReady = 1'b1;
    doneCnt = 0;
    for (int s = 0; s < N; s++) begin
      fork
        automatic int ss = s;
        begin
          for (int k = 0; k < 20; k++)
            sendReq(ss, int'($urandom_range(N-1)), 16'($urandom), 2'($urandom));
          doneCnt++;
        end
      join_none
    end
    wait (doneCnt == N);
    randReady = 1'b0;
    @(negedge clk);
    outReady = '1;
    drain();
    check(pending() == 0, "R2 every random request emerged", 64'(pending()), 64'(0));

    finishRun();
  end

endmodule